// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences power-down for a small processor core. The core raises a one-cycle strobe when it decodes a sleep instruction, and another when it decodes a watchdog-clear instruction. The controller decides whether the sleep really happens. If it does, it gates the core clock off, sends the watchdog a clear pulse and updates two status bits. It then waits for a wake event. When one arrives it restarts the clock and, after a fixed oscillator start-up time, tells the core to resume.

Wake events come from three places. The first is an interrupt source whose flag and enable are both set; this works whatever the global interrupt enable is. The second is a watchdog time-out, which counts only when the watchdog is enabled. The third is the external reset input. When the global enable is set at an interrupt wake, a vector request follows the resume pulse by one cycle. The core then runs the instruction after the sleep and branches to the interrupt address. A sleep request that finds an enabled interrupt already pending completes as a no-op.

All outputs are registered and the block runs from a free-running reference clock. While asleep, the wake inputs are evaluated combinationally in every cycle.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), `core_clk_en` is 1, `sts_no_timeout` and `sts_no_sleep` are both 1, and `wdog_clr`, `resume` and `vec_req` are 0.
- R2: A `sleep_cmd` in the running state with no enabled interrupt pending is accepted. In the next cycle `core_clk_en` is 0, `wdog_clr` is 1 for exactly one cycle, `sts_no_sleep` is 0 and `sts_no_timeout` is 1.
- R3: A `sleep_cmd` seen in a cycle where some source has both its `irq_flag` bit and `irq_en` bit set is a no-op. The clock stays on, no `wdog_clr` pulse is given, and both status bits keep their values.
- R4: A source counts as pending only when its flag bit and its enable bit (same index) are both 1. A flag without its enable neither blocks a sleep nor wakes the block.
- R5: While asleep, a pending interrupt sets `core_clk_en` to 1 in the next cycle, for either value of `irq_global_en`.
- R6: After any non-reset wake, `resume` pulses for one cycle exactly `STARTUP_CYC` cycles after the cycle in which `core_clk_en` returned to 1.
- R7: `vec_req` pulses for one cycle, one cycle after `resume`. This happens only if the wake came from an interrupt and `irq_global_en` was 1 when the wake was taken.
- R8: While asleep, `wdog_timeout` wakes the block only when `wdog_enabled` is 1. Such a wake clears `sts_no_timeout` and never produces `vec_req`.
- R9: `ext_reset` while asleep sets `core_clk_en` to 1 in the next cycle and returns to the running state. It produces no `resume` and leaves both status bits unchanged.
- R10: A `wdog_kick_cmd` in the running state (without `sleep_cmd`) gives a one-cycle `wdog_clr` pulse and sets both `sts_no_timeout` and `sts_no_sleep` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Power-on reset, active low |
| ext_reset | input | 1 | External reset request, active high |
| sleep_cmd | input | 1 | Core decoded a sleep instruction |
| wdog_kick_cmd | input | 1 | Core decoded a watchdog-clear instruction |
| irq_flag | input | N_SRC | Per-source interrupt flags |
| irq_en | input | N_SRC | Per-source interrupt enables |
| irq_global_en | input | 1 | Global interrupt enable |
| wdog_enabled | input | 1 | Watchdog is enabled |
| wdog_timeout | input | 1 | Watchdog time-out event |
| core_clk_en | output | 1 | Oscillator / core clock enable |
| wdog_clr | output | 1 | One-cycle watchdog and postscaler clear |
| sts_no_timeout | output | 1 | Status: 0 after a watchdog time-out wake |
| sts_no_sleep | output | 1 | Status: 0 once a sleep has been taken |
| resume | output | 1 | One-cycle pulse: core may continue |
| vec_req | output | 1 | One-cycle pulse: branch to the interrupt vector |

## Verification
The first sweep covers every flag and enable combination on three sources at the moment of the sleep strobe. Each accepted-or-no-op outcome is compared with the bench's own AND-reduce, which separates a per-source match from any flag/enable mix. A second sweep sleeps with every nonzero enable mask and then raises each single flag under both global-enable values. This separates waking from staying asleep, and a vectored resume from a plain one. Sources that cannot wake are then released by a watchdog time-out, first with the watchdog disabled and then enabled. The no-sleep cases are left through the external reset, which checks that no resume pulse follows.

// File: rtl/slpw_pkg.sv
package slpw_pkg;
    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_SLEEP = 2'd1,
        PH_WARM  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   clk_en;
        logic   wdog_clr;
        logic   sts_no_timeout;
        logic   sts_no_sleep;
        logic   resume;
        logic   vec_req;
        logic   vec_pend;
    } ctl_s;

    localparam ctl_s CTL_RESET = '{
        phase:          PH_RUN,
        clk_en:         1'b1,
        wdog_clr:       1'b0,
        sts_no_timeout: 1'b1,
        sts_no_sleep:   1'b1,
        resume:         1'b0,
        vec_req:        1'b0,
        vec_pend:       1'b0
    };
endpackage

// File: rtl/slpw_irq_pending.sv
module slpw_irq_pending #(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC-1:0] flag,
    input  logic [N_SRC-1:0] en,
    output logic             pending
);
    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = flag[i] & en[i];
    end

    assign pending = |hit;
endmodule

// File: rtl/slpw_warm_timer.sv
module slpw_warm_timer #(
    parameter int STARTUP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (STARTUP_CYC < 2) ? 1 : $clog2(STARTUP_CYC);
    localparam logic [CW-1:0] LAST = CW'(STARTUP_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = '0;
        if (run && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import slpw_pkg::*;
#(
    parameter int N_SRC       = 3,
    parameter int STARTUP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_reset,
    input  logic             sleep_cmd,
    input  logic             wdog_kick_cmd,
    input  logic [N_SRC-1:0] irq_flag,
    input  logic [N_SRC-1:0] irq_en,
    input  logic             irq_global_en,
    input  logic             wdog_enabled,
    input  logic             wdog_timeout,
    output logic             core_clk_en,
    output logic             wdog_clr,
    output logic             sts_no_timeout,
    output logic             sts_no_sleep,
    output logic             resume,
    output logic             vec_req
);
    ctl_s ctl_d, ctl_q;
    logic irq_pending;
    logic warm_done;
    logic wdog_wake;

    slpw_irq_pending #(.N_SRC(N_SRC)) u_pending (
        .flag    (irq_flag),
        .en      (irq_en),
        .pending (irq_pending)
    );

    slpw_warm_timer #(.STARTUP_CYC(STARTUP_CYC)) u_warm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_q.phase == PH_WARM),
        .expired (warm_done)
    );

    assign wdog_wake = wdog_enabled && wdog_timeout;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.wdog_clr = 1'b0;
        ctl_d.resume   = 1'b0;
        ctl_d.vec_req  = 1'b0;
        unique case (ctl_q.phase)
            PH_RUN: begin
                if (ext_reset) begin
                    ctl_d.vec_pend = 1'b0;
                    ctl_d.clk_en   = 1'b1;
                end else begin
                    if (ctl_q.vec_pend) begin
                        ctl_d.vec_req  = 1'b1;
                        ctl_d.vec_pend = 1'b0;
                    end
                    if (sleep_cmd) begin
                        if (!irq_pending) begin
                            ctl_d.phase          = PH_SLEEP;
                            ctl_d.clk_en         = 1'b0;
                            ctl_d.wdog_clr       = 1'b1;
                            ctl_d.sts_no_sleep   = 1'b0;
                            ctl_d.sts_no_timeout = 1'b1;
                        end
                    end else if (wdog_kick_cmd) begin
                        ctl_d.wdog_clr       = 1'b1;
                        ctl_d.sts_no_sleep   = 1'b1;
                        ctl_d.sts_no_timeout = 1'b1;
                    end
                end
            end
            PH_SLEEP: begin
                if (ext_reset) begin
                    ctl_d.phase  = PH_RUN;
                    ctl_d.clk_en = 1'b1;
                end else if (irq_pending) begin
                    ctl_d.phase    = PH_WARM;
                    ctl_d.clk_en   = 1'b1;
                    ctl_d.vec_pend = irq_global_en;
                end else if (wdog_wake) begin
                    ctl_d.phase          = PH_WARM;
                    ctl_d.clk_en         = 1'b1;
                    ctl_d.sts_no_timeout = 1'b0;
                    ctl_d.vec_pend       = 1'b0;
                end
            end
            PH_WARM: begin
                if (ext_reset) begin
                    ctl_d.phase    = PH_RUN;
                    ctl_d.vec_pend = 1'b0;
                end else if (warm_done) begin
                    ctl_d.phase  = PH_RUN;
                    ctl_d.resume = 1'b1;
                end
            end
            default: begin
                ctl_d = CTL_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign core_clk_en    = ctl_q.clk_en;
    assign wdog_clr       = ctl_q.wdog_clr;
    assign sts_no_timeout = ctl_q.sts_no_timeout;
    assign sts_no_sleep   = ctl_q.sts_no_sleep;
    assign resume         = ctl_q.resume;
    assign vec_req        = ctl_q.vec_req;

    // R2: accepted sleep applies all side effects
    a_r2_sleep_effects: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_RUN && !ext_reset && sleep_cmd && !irq_pending)
        |=> (!core_clk_en && wdog_clr && !sts_no_sleep && sts_no_timeout));

    // R3: pending interrupt turns the sleep into a no-op
    a_r3_noop_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_RUN && !ext_reset && sleep_cmd && irq_pending)
        |=> (core_clk_en && !wdog_clr && $stable(sts_no_sleep) && $stable(sts_no_timeout)));

    // R4: with nothing to wake it, the block stays asleep
    a_r4_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_SLEEP && !ext_reset && !irq_pending && !wdog_wake)
        |=> !core_clk_en);

    // R5: pending interrupt wakes regardless of the global enable
    a_r5_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_SLEEP && !ext_reset && irq_pending) |=> core_clk_en);

    // R6: resume is a single-cycle pulse
    a_r6_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);

    // R7: vector request only directly after resume
    a_r7_vec_after_resume: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(resume));

    // R8: enabled watchdog time-out wakes and clears the status bit
    a_r8_wdog_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_SLEEP && !ext_reset && !irq_pending && wdog_wake)
        |=> (core_clk_en && !sts_no_timeout));

    // R9: external reset leaves sleep without a resume
    a_r9_ext_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_SLEEP && ext_reset)
        |=> (core_clk_en && !resume && $stable(sts_no_sleep) && $stable(sts_no_timeout)));

    // R10: watchdog-clear instruction restores both status bits
    a_r10_kick: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_RUN && !ext_reset && !sleep_cmd && wdog_kick_cmd)
        |=> (wdog_clr && sts_no_sleep && sts_no_timeout));
endmodule

// File: tb/sleep_wake_ctrl_bench.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_bench;
    localparam int NS = 3;
    localparam int SC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_reset = 1'b0;
    logic sleep_cmd = 1'b0;
    logic wdog_kick_cmd = 1'b0;
    logic [NS-1:0] irq_flag = '0;
    logic [NS-1:0] irq_en = '0;
    logic irq_global_en = 1'b0;
    logic wdog_enabled = 1'b0;
    logic wdog_timeout = 1'b0;
    logic core_clk_en, wdog_clr, sts_no_timeout, sts_no_sleep, resume, vec_req;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    sleep_wake_ctrl #(.N_SRC(NS), .STARTUP_CYC(SC)) u_sleep_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_reset(ext_reset), .sleep_cmd(sleep_cmd),
        .wdog_kick_cmd(wdog_kick_cmd), .irq_flag(irq_flag), .irq_en(irq_en),
        .irq_global_en(irq_global_en), .wdog_enabled(wdog_enabled),
        .wdog_timeout(wdog_timeout), .core_clk_en(core_clk_en), .wdog_clr(wdog_clr),
        .sts_no_timeout(sts_no_timeout), .sts_no_sleep(sts_no_sleep),
        .resume(resume), .vec_req(vec_req)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic kick();
        wdog_kick_cmd = 1'b1;
        tick();
        wdog_kick_cmd = 1'b0;
    endtask

    // wait for resume after a wake edge already sampled, then check vector
    task automatic expect_resume(input logic exp_vec, input string tag);
        for (int k = 1; k < SC; k++) begin
            tick();
            chk({tag, " R6 resume early"}, resume, 1'b0);
        end
        tick();
        chk({tag, " R6 resume pulse"}, resume, 1'b1);
        chk({tag, " R7 no vec with resume"}, vec_req, 1'b0);
        tick();
        chk({tag, " R6 resume width"}, resume, 1'b0);
        chk({tag, " R7 vec_req"}, vec_req, exp_vec);
        tick();
        chk({tag, " R7 vec width"}, vec_req, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 clk_en", core_clk_en, 1'b1);
        chk("R1 no_timeout", sts_no_timeout, 1'b1);
        chk("R1 no_sleep", sts_no_sleep, 1'b1);
        chk("R1 wdog_clr", wdog_clr, 1'b0);
        chk("R1 resume", resume, 1'b0);
        chk("R1 vec_req", vec_req, 1'b0);

        // R10 kick
        kick();
        chk("R10 wdog_clr", wdog_clr, 1'b1);
        chk("R10 no_sleep", sts_no_sleep, 1'b1);
        chk("R10 no_timeout", sts_no_timeout, 1'b1);
        tick();
        chk("R10 clr width", wdog_clr, 1'b0);

        // Sweep A: all flag/enable patterns at the sleep strobe (R2, R3, R4, R9)
        for (int f = 0; f < 8; f++) begin
            for (int e = 0; e < 8; e++) begin
                logic will_sleep;
                kick();
                will_sleep = ((f & e) == 0);
                irq_flag = NS'(f);
                irq_en = NS'(e);
                sleep_cmd = 1'b1;
                tick();
                sleep_cmd = 1'b0;
                irq_flag = '0;
                if (will_sleep) begin
                    chk("R2 R4 clk off", core_clk_en, 1'b0);
                    chk("R2 wdog_clr", wdog_clr, 1'b1);
                    chk("R2 no_sleep", sts_no_sleep, 1'b0);
                    chk("R2 no_timeout", sts_no_timeout, 1'b1);
                    tick();
                    chk("R2 clr width", wdog_clr, 1'b0);
                    chk("R2 still asleep", core_clk_en, 1'b0);
                    ext_reset = 1'b1;
                    tick();
                    ext_reset = 1'b0;
                    chk("R9 clk on", core_clk_en, 1'b1);
                    chk("R9 no_sleep kept", sts_no_sleep, 1'b0);
                    chk("R9 no_timeout kept", sts_no_timeout, 1'b1);
                    for (int k = 0; k < SC + 2; k++) begin
                        chk("R9 no resume", resume, 1'b0);
                        tick();
                    end
                end else begin
                    chk("R3 clk stays", core_clk_en, 1'b1);
                    chk("R3 no wdog_clr", wdog_clr, 1'b0);
                    chk("R3 no_sleep kept", sts_no_sleep, 1'b1);
                    chk("R3 no_timeout kept", sts_no_timeout, 1'b1);
                end
            end
        end

        // Sweep B: single-source wake for each enable mask and global enable (R4, R5, R6, R7, R8)
        for (int e = 1; e < 8; e++) begin
            for (int b = 0; b < NS; b++) begin
                for (int g = 0; g < 2; g++) begin
                    logic can_wake;
                    kick();
                    irq_en = NS'(e);
                    irq_global_en = g[0];
                    irq_flag = '0;
                    sleep_cmd = 1'b1;
                    tick();
                    sleep_cmd = 1'b0;
                    chk("R2 asleep", core_clk_en, 1'b0);
                    can_wake = e[b];
                    irq_flag = NS'(1) << b;
                    tick();
                    irq_flag = '0;
                    chk("R4 R5 wake decision", core_clk_en, can_wake);
                    if (can_wake) begin
                        expect_resume(g[0], "irq");
                    end else begin
                        wdog_timeout = 1'b1;
                        wdog_enabled = 1'b0;
                        tick();
                        chk("R8 disabled wdog no wake", core_clk_en, 1'b0);
                        wdog_enabled = 1'b1;
                        tick();
                        wdog_timeout = 1'b0;
                        wdog_enabled = 1'b0;
                        chk("R8 wdog wake", core_clk_en, 1'b1);
                        chk("R8 no_timeout cleared", sts_no_timeout, 1'b0);
                        expect_resume(1'b0, "wdog R8");
                    end
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule